// File: doc/BRIEF.md
# Lowest-Priority Interrupt Redirection Table

This block holds one task-priority record for each of 16 interrupt-capable processor agents. Each record keeps a 4-bit task priority, a priority-enable flag, an 8-bit physical interrupt-controller ID and an 8-bit logical ID. Records are filled by snooping task-priority update transactions on two processor buses. The bus decoder upstream gives a one-cycle strobe, a 4-bit record index and the two 32-bit address phases of the transaction. The fields are taken from fixed bit positions in those phases.

A combinational arbiter scans the table and reports the record that is enabled and has the numerically lowest priority. The interrupt router uses this result to steer a redirectable interrupt to that agent. A flag is raised when no record is enabled.

Software can read and write every record as a 32-bit word through a simple register port. The records sit at byte offsets 80h through BCh, one word per record in index order. Record 0 also carries a global cluster-mode bit. Only flat mode, where the bit is 0, is meaningful.

Top module: `lpr_redirect_table`

## Requirements
- R1: After reset every record word reads 0, `tgt_none_o` is 1 and `tgt_idx_o` is 0.
- R2: An update on a bus writes the record chosen by its index one cycle later, with these fields: logical ID from A[11:4] into word bits 7:0; physical ID from A[19:12] into bits 15:8; priority from B[27:24] into bits 19:16; enable, the inverse of the active-low B[31], into bit 23. All other bits of A and B have no effect on the record fields.
- R3: Updates on both buses in the same cycle to different records are both applied. When both target the same record, the bus 0 values are stored.
- R4: Every bus update, whatever its index, loads A[3] into bit 31 of record 0. If both buses update in the same cycle, bus 0 provides the bit. Bit 31 of records 1 to 15 always reads 0.
- R5: A register write to offset 80h+4*i replaces bits 23, 19:16, 15:8 and 7:0 of record i with the same bits of the write data. A write to record 0 also loads bit 31. A bus update to the same record in the same cycle takes precedence over the register write, and any bus update takes precedence over it for bit 31.
- R6: Bits 30:24 and 22:20 of every record always read 0, whatever is written.
- R7: A register access below 80h or above BFh reads 0, and a write there changes no record.
- R8: When at least one record is enabled, `tgt_idx_o` names an enabled record whose priority is not greater than that of any other enabled record, and `tgt_none_o` is 0.
- R9: Among enabled records that tie on the lowest priority, the lowest index is reported.
- R10: When no record is enabled, `tgt_none_o` is 1 and `tgt_idx_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| upd0_valid_i | input | 1 | Bus 0 update strobe |
| upd0_idx_i | input | 4 | Bus 0 target record index |
| upd0_a_i | input | 32 | Bus 0 first address phase |
| upd0_b_i | input | 32 | Bus 0 second address phase |
| upd1_valid_i | input | 1 | Bus 1 update strobe |
| upd1_idx_i | input | 4 | Bus 1 target record index |
| upd1_a_i | input | 32 | Bus 1 first address phase |
| upd1_b_i | input | 32 | Bus 1 second address phase |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | 8 | Register byte offset (low two bits ignored) |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` |
| tgt_idx_o | output | 4 | Record chosen for a redirectable interrupt |
| tgt_none_o | output | 1 | No record is enabled |

## Verification
The arbiter is tested against several table contents:
- one enabled record among disabled ones, which shows that the enable flag masks records out;
- several enabled records with different priorities, which shows that a true minimum search is done and not first-found;
- tied lowest priorities, which confirms the lowest-index rule;
- a table with every record disabled, which checks the empty case.

The update path is tested in several ways:
- address phases that carry ones in every unused bit, which shows that the fixed field slices are used;
- both buses striking the same record and striking different records, which separates the precedence rule from plain merging;
- a register write racing a bus update to the same record;
- register accesses just outside the window.

// File: rtl/lpr_pkg.sv
package lpr_pkg;
  localparam int PRIO_W = 4;
  localparam int ID_W   = 8;

  typedef struct packed {
    logic              en;
    logic [PRIO_W-1:0] prio;
    logic [ID_W-1:0]   phys;
    logic [ID_W-1:0]   logi;
  } entry_t;

  // word layout of one record
  localparam int BIT_CLUSTER = 31;
  localparam int BIT_EN      = 23;
  localparam int BIT_PRIO_LO = 16;
  localparam int BIT_PHYS_LO = 8;
  localparam int BIT_LOGI_LO = 0;

  localparam logic [7:0] REG_BASE = 8'h80;
endpackage

// File: rtl/lpr_entry_file.sv
module lpr_entry_file
  import lpr_pkg::*;
#(
  parameter int N_ENT = 16,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [1:0]             upd_valid_i,
  input  logic [1:0][IDX_W-1:0]  upd_idx_i,
  input  logic [1:0][31:0]       upd_a_i,
  input  logic [1:0][31:0]       upd_b_i,
  input  logic [N_ENT-1:0]       wr_hit_i,
  input  entry_t                 wr_ent_i,
  input  logic                   wr_cluster_i,
  output entry_t [N_ENT-1:0]     ent_o,
  output logic                   cluster_o
);
  entry_t [1:0] bus_ent;
  logic   [1:0] bus_cl;
  logic         unused_bus_bits;

  for (genvar b = 0; b < 2; b++) begin : g_bus
    assign bus_ent[b].logi = upd_a_i[b][11:4];
    assign bus_ent[b].phys = upd_a_i[b][19:12];
    assign bus_ent[b].prio = upd_b_i[b][27:24];
    assign bus_ent[b].en   = ~upd_b_i[b][31];
    assign bus_cl[b]       = upd_a_i[b][3];
  end

  assign unused_bus_bits = ^{upd_a_i[0][31:20], upd_a_i[0][2:0], upd_b_i[0][30:28], upd_b_i[0][23:0],
                             upd_a_i[1][31:20], upd_a_i[1][2:0], upd_b_i[1][30:28], upd_b_i[1][23:0]};

  entry_t [N_ENT-1:0] ent_q;

  for (genvar i = 0; i < N_ENT; i++) begin : g_ent
    logic hit0, hit1;
    assign hit0 = upd_valid_i[0] && (upd_idx_i[0] == IDX_W'(i));
    assign hit1 = upd_valid_i[1] && (upd_idx_i[1] == IDX_W'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          ent_q[i] <= '0;
      else if (hit0)        ent_q[i] <= bus_ent[0];
      else if (hit1)        ent_q[i] <= bus_ent[1];
      else if (wr_hit_i[i]) ent_q[i] <= wr_ent_i;
    end
  end

  // global mode bit lives beside record 0; any bus update refreshes it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cluster_o <= 1'b0;
    else if (upd_valid_i[0]) cluster_o <= bus_cl[0];
    else if (upd_valid_i[1]) cluster_o <= bus_cl[1];
    else if (wr_hit_i[0])    cluster_o <= wr_cluster_i;
  end

  assign ent_o = ent_q;
endmodule

// File: rtl/lpr_min_select.sv
module lpr_min_select
  import lpr_pkg::*;
#(
  parameter int N_ENT = 16,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  entry_t [N_ENT-1:0] ent_i,
  output logic [IDX_W-1:0]   idx_o,
  output logic               none_o
);
  logic [PRIO_W-1:0] best_prio;
  logic              found;

  // ascending scan with strict compare keeps the lowest index on ties
  always_comb begin
    idx_o     = '0;
    best_prio = '1;
    found     = 1'b0;
    for (int i = 0; i < N_ENT; i++) begin
      if (ent_i[i].en && (!found || ent_i[i].prio < best_prio)) begin
        idx_o     = IDX_W'(i);
        best_prio = ent_i[i].prio;
        found     = 1'b1;
      end
    end
    none_o = !found;
  end
endmodule

// File: rtl/lpr_reg_view.sv
module lpr_reg_view
  import lpr_pkg::*;
#(
  parameter int N_ENT = 16,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic               we_i,
  input  logic [7:0]         addr_i,
  input  logic [31:0]        wdata_i,
  input  entry_t [N_ENT-1:0] ent_i,
  input  logic               cluster_i,
  output logic [N_ENT-1:0]   wr_hit_o,
  output entry_t             wr_ent_o,
  output logic               wr_cluster_o,
  output logic [31:0]        rdata_o
);
  localparam int SPAN = 4 * N_ENT;

  logic [8:0]       off;
  logic             in_win;
  logic [IDX_W-1:0] idx;
  logic             unused_reg_bits;

  assign off    = {1'b0, addr_i} - {1'b0, REG_BASE};
  assign in_win = (addr_i >= REG_BASE) && ({1'b0, addr_i} < ({1'b0, REG_BASE} + 9'(SPAN)));
  assign idx    = off[IDX_W+1:2];

  assign unused_reg_bits = ^{off[8:IDX_W+2], off[1:0], wdata_i[30:24], wdata_i[22:20]};

  for (genvar i = 0; i < N_ENT; i++) begin : g_hit
    assign wr_hit_o[i] = we_i && in_win && (idx == IDX_W'(i));
  end

  assign wr_ent_o.en   = wdata_i[BIT_EN];
  assign wr_ent_o.prio = wdata_i[BIT_PRIO_LO +: PRIO_W];
  assign wr_ent_o.phys = wdata_i[BIT_PHYS_LO +: ID_W];
  assign wr_ent_o.logi = wdata_i[BIT_LOGI_LO +: ID_W];
  assign wr_cluster_o  = wdata_i[BIT_CLUSTER];

  always_comb begin
    rdata_o = '0;
    if (in_win) begin
      rdata_o[BIT_EN]                   = ent_i[idx].en;
      rdata_o[BIT_PRIO_LO +: PRIO_W]    = ent_i[idx].prio;
      rdata_o[BIT_PHYS_LO +: ID_W]      = ent_i[idx].phys;
      rdata_o[BIT_LOGI_LO +: ID_W]      = ent_i[idx].logi;
      rdata_o[BIT_CLUSTER]              = (idx == '0) && cluster_i;
    end
  end
endmodule

// File: rtl/lpr_redirect_table.sv
module lpr_redirect_table
  import lpr_pkg::*;
#(
  parameter int N_ENT = 16,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             upd0_valid_i,
  input  logic [IDX_W-1:0] upd0_idx_i,
  input  logic [31:0]      upd0_a_i,
  input  logic [31:0]      upd0_b_i,
  input  logic             upd1_valid_i,
  input  logic [IDX_W-1:0] upd1_idx_i,
  input  logic [31:0]      upd1_a_i,
  input  logic [31:0]      upd1_b_i,
  input  logic             reg_we_i,
  input  logic [7:0]       reg_addr_i,
  input  logic [31:0]      reg_wdata_i,
  output logic [31:0]      reg_rdata_o,
  output logic [IDX_W-1:0] tgt_idx_o,
  output logic             tgt_none_o
);
  entry_t [N_ENT-1:0] ent_q;
  logic               cluster_q;
  logic [N_ENT-1:0]   wr_hit;
  entry_t             wr_ent;
  logic               wr_cluster;

  lpr_entry_file #(.N_ENT(N_ENT)) u_file (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .upd_valid_i  ({upd1_valid_i, upd0_valid_i}),
    .upd_idx_i    ({upd1_idx_i, upd0_idx_i}),
    .upd_a_i      ({upd1_a_i, upd0_a_i}),
    .upd_b_i      ({upd1_b_i, upd0_b_i}),
    .wr_hit_i     (wr_hit),
    .wr_ent_i     (wr_ent),
    .wr_cluster_i (wr_cluster),
    .ent_o        (ent_q),
    .cluster_o    (cluster_q)
  );

  lpr_reg_view #(.N_ENT(N_ENT)) u_regs (
    .we_i         (reg_we_i),
    .addr_i       (reg_addr_i),
    .wdata_i      (reg_wdata_i),
    .ent_i        (ent_q),
    .cluster_i    (cluster_q),
    .wr_hit_o     (wr_hit),
    .wr_ent_o     (wr_ent),
    .wr_cluster_o (wr_cluster),
    .rdata_o      (reg_rdata_o)
  );

  lpr_min_select #(.N_ENT(N_ENT)) u_sel (
    .ent_i  (ent_q),
    .idx_o  (tgt_idx_o),
    .none_o (tgt_none_o)
  );
endmodule

// File: rtl/lpr_redirect_table_chk.sv
module lpr_redirect_table_chk
  import lpr_pkg::*;
#(
  parameter int N_ENT = 16,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               upd0_valid_i,
  input logic [IDX_W-1:0]   upd0_idx_i,
  input logic [31:0]        upd0_a_i,
  input logic [31:0]        upd0_b_i,
  input logic               upd1_valid_i,
  input logic [IDX_W-1:0]   upd1_idx_i,
  input logic [31:0]        upd1_a_i,
  input logic [31:0]        upd1_b_i,
  input logic               reg_we_i,
  input logic [7:0]         reg_addr_i,
  input logic [31:0]        reg_wdata_i,
  input logic [31:0]        reg_rdata_o,
  input logic [IDX_W-1:0]   tgt_idx_o,
  input logic               tgt_none_o,
  input entry_t [N_ENT-1:0] ent_q,
  input logic               cluster_q
);
  logic             any_en, beaten;
  logic             in_win;
  logic [IDX_W-1:0] w_idx;
  logic [8:0]       w_off;

  always_comb begin
    any_en = 1'b0;
    beaten = 1'b0;
    for (int i = 0; i < N_ENT; i++) begin
      if (ent_q[i].en) any_en = 1'b1;
      if (ent_q[i].en && ent_q[i].prio < ent_q[tgt_idx_o].prio) beaten = 1'b1;
      if (ent_q[i].en && ent_q[i].prio == ent_q[tgt_idx_o].prio && IDX_W'(i) < tgt_idx_o) beaten = 1'b1;
    end
  end

  assign w_off  = {1'b0, reg_addr_i} - {1'b0, REG_BASE};
  assign in_win = (reg_addr_i >= REG_BASE) && (w_off < 9'(4 * N_ENT));
  assign w_idx  = w_off[IDX_W+1:2];

  AST_NONE_IDX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tgt_none_o |-> (tgt_idx_o == '0) && !any_en); // R10
  AST_TGT_ENABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_en |-> !tgt_none_o && ent_q[tgt_idx_o].en); // R8
  AST_TGT_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tgt_none_o |-> !beaten); // R9
  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rdata_o[30:24] == '0) && (reg_rdata_o[22:20] == '0)); // R6
  AST_OUT_WIN_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_win |-> reg_rdata_o == '0); // R7
  AST_BUS0_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd0_valid_i |=> ent_q[$past(upd0_idx_i)] ==
      {~$past(upd0_b_i[31]), $past(upd0_b_i[27:24]), $past(upd0_a_i[19:12]), $past(upd0_a_i[11:4])}); // R2
  AST_BUS1_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd1_valid_i && !(upd0_valid_i && upd0_idx_i == upd1_idx_i) |=> ent_q[$past(upd1_idx_i)] ==
      {~$past(upd1_b_i[31]), $past(upd1_b_i[27:24]), $past(upd1_a_i[19:12]), $past(upd1_a_i[11:4])}); // R3
  AST_CLUSTER_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd0_valid_i || upd1_valid_i) |=>
      cluster_q == $past(upd0_valid_i ? upd0_a_i[3] : upd1_a_i[3])); // R4
  AST_REG_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i && in_win && !(upd0_valid_i && upd0_idx_i == w_idx) && !(upd1_valid_i && upd1_idx_i == w_idx)
      |=> ent_q[$past(w_idx)] == {$past(reg_wdata_i[23]), $past(reg_wdata_i[19:0])}); // R5
endmodule

bind lpr_redirect_table lpr_redirect_table_chk #(.N_ENT(N_ENT)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .upd0_valid_i(upd0_valid_i), .upd0_idx_i(upd0_idx_i), .upd0_a_i(upd0_a_i), .upd0_b_i(upd0_b_i),
  .upd1_valid_i(upd1_valid_i), .upd1_idx_i(upd1_idx_i), .upd1_a_i(upd1_a_i), .upd1_b_i(upd1_b_i),
  .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
  .tgt_idx_o(tgt_idx_o), .tgt_none_o(tgt_none_o), .ent_q(ent_q), .cluster_q(cluster_q)
);

// File: tb/sim_lpr_redirect_table.sv
module sim_lpr_redirect_table;
  timeunit 1ns;
  timeprecision 100ps;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        u0v = 0, u1v = 0;
  logic [3:0]  u0i = 0, u1i = 0;
  logic [31:0] u0a = 0, u0b = 0, u1a = 0, u1b = 0;
  logic        we = 0;
  logic [7:0]  ra = 0;
  logic [31:0] wd = 0;
  logic [31:0] rd;
  logic [3:0]  tidx;
  logic        tnone;

  int n_chk = 0, n_fail = 0;

  // model built from the requirements
  logic       m_en [16];
  logic [3:0] m_pr [16];
  logic [7:0] m_ph [16];
  logic [7:0] m_lg [16];
  logic       m_cl;

  always #2.5 clk = ~clk;

  lpr_redirect_table u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .upd0_valid_i(u0v), .upd0_idx_i(u0i), .upd0_a_i(u0a), .upd0_b_i(u0b),
    .upd1_valid_i(u1v), .upd1_idx_i(u1i), .upd1_a_i(u1a), .upd1_b_i(u1b),
    .reg_we_i(we), .reg_addr_i(ra), .reg_wdata_i(wd), .reg_rdata_o(rd),
    .tgt_idx_o(tidx), .tgt_none_o(tnone)
  );

  function automatic logic [31:0] mk_a(input logic [7:0] ph, input logic [7:0] lg, input logic cl,
                                       input logic junk);
    return {junk ? 12'hFFF : 12'h000, ph, lg, cl, junk ? 3'b111 : 3'b000};
  endfunction

  function automatic logic [31:0] mk_b(input logic en_n, input logic [3:0] pr, input logic junk);
    return {en_n, junk ? 3'b111 : 3'b000, pr, junk ? 24'hFFFFFF : 24'h0};
  endfunction

  function automatic logic [31:0] exp_word(input int i);
    return {(i == 0) ? m_cl : 1'b0, 7'b0, m_en[i], 3'b0, m_pr[i], m_ph[i], m_lg[i]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_sel(input string req);
    int best = -1;
    for (int i = 0; i < 16; i++)
      if (m_en[i] && (best < 0 || m_pr[i] < m_pr[best])) best = i;
    check(req, {27'b0, tnone, tidx}, {27'b0, best < 0, best < 0 ? 4'd0 : 4'(best)});
  endtask

  task automatic check_table(input string req);
    for (int i = 0; i < 16; i++) begin
      ra = 8'h80 + 8'(4 * i);
      #0.5;
      check(req, rd, exp_word(i));
    end
  endtask

  // one cycle of stimulus, model updated with precedence reg < bus1 < bus0
  task automatic cycle(input logic v0, input logic [3:0] i0, input logic [31:0] a0, input logic [31:0] b0,
                       input logic v1, input logic [3:0] i1, input logic [31:0] a1, input logic [31:0] b1,
                       input logic w, input logic [7:0] wa, input logic [31:0] wdat);
    @(negedge clk);
    u0v = v0; u0i = i0; u0a = a0; u0b = b0;
    u1v = v1; u1i = i1; u1a = a1; u1b = b1;
    we = w; ra = wa; wd = wdat;
    if (w && wa >= 8'h80 && wa <= 8'hBF) begin
      int k = (wa - 8'h80) >> 2;
      m_en[k] = wdat[23]; m_pr[k] = wdat[19:16]; m_ph[k] = wdat[15:8]; m_lg[k] = wdat[7:0];
      if (k == 0) m_cl = wdat[31];
    end
    if (v1) begin
      m_en[i1] = ~b1[31]; m_pr[i1] = b1[27:24]; m_ph[i1] = a1[19:12]; m_lg[i1] = a1[11:4]; m_cl = a1[3];
    end
    if (v0) begin
      m_en[i0] = ~b0[31]; m_pr[i0] = b0[27:24]; m_ph[i0] = a0[19:12]; m_lg[i0] = a0[11:4]; m_cl = a0[3];
    end
    @(negedge clk);
    u0v = 0; u1v = 0; we = 0;
  endtask

  task automatic bus0(input logic [3:0] i, input logic en_n, input logic [3:0] pr, input logic [7:0] ph,
                      input logic [7:0] lg);
    cycle(1, i, mk_a(ph, lg, 0, 1), mk_b(en_n, pr, 1), 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_reset;
    check_table("R1");
    check_sel("R1 R10");
  endtask

  task automatic t_bus_load;
    bus0(4'd5, 1'b0, 4'd9, 8'hA5, 8'h3C);  // unused address bits all ones
    cycle(0, 0, 0, 0, 1, 4'd7, mk_a(8'h11, 8'h22, 0, 1), mk_b(1'b1, 4'd2, 1), 0, 0, 0);
    ra = 8'h94; #0.5;
    check("R2 word layout", rd, 32'h0089A53C);
    check_table("R2");
    check_sel("R8 single enabled");
  endtask

  task automatic t_dual;
    cycle(1, 4'd3, mk_a(8'h33, 8'h03, 0, 0), mk_b(0, 4'd4, 0),
          1, 4'd12, mk_a(8'hCC, 8'h0C, 0, 0), mk_b(0, 4'd6, 0), 0, 0, 0);
    check_table("R3 different records");
    cycle(1, 4'd3, mk_a(8'h77, 8'h70, 0, 0), mk_b(0, 4'd1, 0),
          1, 4'd3, mk_a(8'h88, 8'h80, 0, 0), mk_b(0, 4'd8, 0), 0, 0, 0);
    ra = 8'h8C; #0.5;
    check("R3 bus0 wins", rd, 32'h00817770);
    check_sel("R8 multi");
  endtask

  task automatic t_cluster;
    cycle(0, 0, 0, 0, 1, 4'd9, mk_a(8'h09, 8'h99, 1, 0), mk_b(1, 4'd0, 0), 0, 0, 0);
    ra = 8'h80; #0.5;
    check("R4 cluster set by bus1", {31'b0, rd[31]}, 32'd1);
    ra = 8'hA4; #0.5;
    check("R4 other record bit31", {31'b0, rd[31]}, 32'd0);
    cycle(1, 4'd10, mk_a(8'h0A, 8'hAA, 0, 0), mk_b(1, 4'd0, 0),
          1, 4'd11, mk_a(8'h0B, 8'hBB, 1, 0), mk_b(1, 4'd0, 0), 0, 0, 0);
    ra = 8'h80; #0.5;
    check("R4 bus0 supplies bit", {31'b0, rd[31]}, 32'd0);
    check_table("R4");
  endtask

  task automatic t_reg;
    cycle(0, 0, 0, 0, 0, 0, 0, 0, 1, 8'hA8, 32'hFFFFFFFF);
    ra = 8'hA8; #0.5;
    check("R6 reserved zero", rd, 32'h008FFFFF);
    cycle(0, 0, 0, 0, 0, 0, 0, 0, 1, 8'h80, 32'h80812345);
    check_table("R5 reg write");
    // bus update to same record beats register write
    cycle(1, 4'd14, mk_a(8'hE0, 8'h0E, 0, 0), mk_b(0, 4'd7, 0), 0, 0, 0, 0, 1, 8'hB8, 32'h00835555);
    ra = 8'hB8; #0.5;
    check("R5 bus beats reg", rd, 32'h0087E00E);
    // bus update elsewhere beats register write for the mode bit
    cycle(1, 4'd2, mk_a(8'h20, 8'h02, 0, 0), mk_b(1, 4'd3, 0), 0, 0, 0, 0, 1, 8'h80, 32'h80800000);
    ra = 8'h80; #0.5;
    check("R5 bus beats reg bit31", rd, 32'h00800000);
    check_sel("R8 after reg");
  endtask

  task automatic t_window;
    cycle(0, 0, 0, 0, 0, 0, 0, 0, 1, 8'h7C, 32'hFFFFFFFF);
    cycle(0, 0, 0, 0, 0, 0, 0, 0, 1, 8'hC0, 32'hFFFFFFFF);
    ra = 8'h7C; #0.5;
    check("R7 below window", rd, 32'h0);
    ra = 8'hC0; #0.5;
    check("R7 above window", rd, 32'h0);
    check_table("R7 unchanged");
  endtask

  task automatic t_tie;
    for (int i = 0; i < 16; i++) bus0(4'(i), 1'b0, 4'd9, 8'(i), 8'(i));
    bus0(4'd13, 1'b0, 4'd2, 8'h0D, 8'hD0);
    bus0(4'd6, 1'b0, 4'd2, 8'h06, 8'h60);
    bus0(4'd11, 1'b0, 4'd2, 8'h0B, 8'hB0);
    check("R9 tie lowest index", {27'b0, tnone, tidx}, {27'b0, 1'b0, 4'd6});
    bus0(4'd0, 1'b1, 4'd0, 8'h00, 8'h00);  // disabled prio 0 ignored
    check("R8 disabled ignored", {27'b0, tnone, tidx}, {27'b0, 1'b0, 4'd6});
    bus0(4'd15, 1'b0, 4'd0, 8'h0F, 8'hF0);
    check("R8 true minimum", {27'b0, tnone, tidx}, {27'b0, 1'b0, 4'd15});
    check_sel("R9");
  endtask

  task automatic t_none;
    for (int i = 15; i >= 0; i--) bus0(4'(i), 1'b1, 4'd5, 8'h00, 8'h00);
    check("R10 empty", {27'b0, tnone, tidx}, {27'b0, 1'b1, 4'd0});
    check_table("R10");
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin m_en[i] = 0; m_pr[i] = 0; m_ph[i] = 0; m_lg[i] = 0; end
    m_cl = 0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_bus_load;
    t_dual;
    t_cluster;
    t_reg;
    t_window;
    t_tie;
    t_none;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule